// File: doc/BRIEF.md
# Predicated Vector-Add Element Sequencer

This block turns one scalar-style add command into a loop of element additions over a 32-entry integer register file. A small remap table holds a vector tag and a base index for each architectural register. When an operand is tagged, the block redirects it to the stored base and walks through consecutive registers from there. An untagged operand keeps its own register number and feeds the same value to every element.

A second per-register table can give the destination's architectural number a predicate. The predicate names an integer register whose bits gate the elements. This lookup uses the destination number as written in the command, before any remapping takes place.

Commands arrive on a valid/ready pair. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While the loop runs, or in the one-cycle completion slot after it, `cmd_ready` stays low, and the source must hold its command until it sees ready. Busy, done and error are plain status pins. The register file has a plain write port and a combinational read port that the surrounding logic uses to load operands and collect results. The two tables each have a plain write port.

Top module: `vadd_seq`

## Requirements
- R1: For each of rd, rs1 and rs2, the operand register is the table's base index when that register's vector tag is 1, and the register's own number when the tag is 0. Tags and bases are captured when the command is accepted.
- R2: Element i writes dst+od the value src1+oa plus src2+ob (32-bit wraparound). Each offset equals i for a tagged operand and 0 for an untagged one, so an untagged source is broadcast. Elements run in increasing i, and a later element reads what an earlier one wrote.
- R3: If the predicate entry of the unmapped rd is enabled, the mask is the contents of the register it names, read when the command is accepted. Bit i of that mask gates element i. If the entry is disabled, the mask is all ones. Offsets advance on masked-off elements as well.
- R4: Exactly min(VL, 32) elements are processed. A VL of 0 raises done in the cycle after acceptance and writes nothing.
- R5: busy is high for exactly min(VL, 32) cycles, starting in the cycle after acceptance. done is high for the single cycle after the last busy cycle. cmd_ready is high only when neither busy nor done is high.
- R6: Register 0 always reads 0. Writes to register 0 from the element loop or from the external port are discarded.
- R7: An unmasked element in which any computed register number exceeds 31 writes nothing and sets err. err is cleared when a command is accepted and holds its value from the done cycle until the next acceptance.
- R8: An external register write takes effect at the next clock edge when busy is low, and is ignored while busy is high.
- R9: Table writes made while a command runs do not affect that command. They apply to commands accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears registers and tables |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command will be taken |
| cmd_rd | input | 5 | Architectural destination register |
| cmd_rs1 | input | 5 | Architectural first source register |
| cmd_rs2 | input | 5 | Architectural second source register |
| cmd_vl | input | 6 | Element count, values above 32 treated as 32 |
| busy | output | 1 | Element loop running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Out-of-range element seen in the last command |
| map_we | input | 1 | Remap table write strobe |
| map_sel | input | 5 | Remap entry written |
| map_vec | input | 1 | Vector tag written |
| map_base | input | 5 | Base index written |
| pcfg_we | input | 1 | Predicate table write strobe |
| pcfg_sel | input | 5 | Predicate entry written |
| pcfg_en | input | 1 | Predicate enable written |
| pcfg_src | input | 5 | Register holding the mask |
| rf_we | input | 1 | External register write strobe |
| rf_waddr | input | 5 | External write register |
| rf_wdata | input | 32 | External write data |
| rf_raddr | input | 5 | External read register |
| rf_rdata | output | 32 | Combinational read data |

## Verification
Results are due at these points:

- busy appears one cycle after the accepting edge.
- Element i is written on the edge that closes the (i+1)-th busy cycle.
- done and the final err value appear min(VL, 32)+1 cycles after acceptance.
- External and table writes become visible one edge after their strobe.

The bench drives inputs on falling edges and samples on falling edges. It counts busy cycles until done and compares that count and err in the done cycle. It reads back every register only after done has dropped. Expected contents come from a sequential arithmetic model of the element loop, run over tag combinations, lengths, masks and out-of-range bases.

// File: rtl/vseq_pkg.sv
`timescale 1ns/1ps
package vseq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_state_e;
  localparam int OPN    = 3;
  localparam int OP_DST = 0;
  localparam int OP_SA  = 1;
  localparam int OP_SB  = 2;
endpackage

// File: rtl/vseq_regfile.sv
`timescale 1ns/1ps
module vseq_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int AW    = 5,
  parameter int NRD   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] mem [NREGS];

  // entry 0 is cleared at reset and never written (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NREGS; e++) mem[e] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/vseq_remap.sv
`timescale 1ns/1ps
module vseq_remap import vseq_pkg::*; #(
  parameter int NREGS = 32,
  parameter int AW    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     map_we,
  input  logic [AW-1:0]            map_sel,
  input  logic                     map_vec,
  input  logic [AW-1:0]            map_base,
  input  logic                     pcfg_we,
  input  logic [AW-1:0]            pcfg_sel,
  input  logic                     pcfg_en,
  input  logic [AW-1:0]            pcfg_src,
  input  logic [OPN-1:0][AW-1:0]   arch,
  output logic [OPN-1:0]           is_vec,
  output logic [OPN-1:0][AW-1:0]   resolved,
  output logic                     pred_en,
  output logic [AW-1:0]            pred_src
);
  logic [NREGS-1:0] vec_tab;
  logic [AW-1:0]    base_tab [NREGS];
  logic [NREGS-1:0] pen_tab;
  logic [AW-1:0]    psrc_tab [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_tab <= '0;
      for (int e = 0; e < NREGS; e++) base_tab[e] <= '0;
    end else if (map_we) begin
      vec_tab[map_sel]  <= map_vec;
      base_tab[map_sel] <= map_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_tab <= '0;
      for (int e = 0; e < NREGS; e++) psrc_tab[e] <= '0;
    end else if (pcfg_we) begin
      pen_tab[pcfg_sel]  <= pcfg_en;
      psrc_tab[pcfg_sel] <= pcfg_src;
    end
  end

  // R1: tagged operands are redirected to their base index
  for (genvar k = 0; k < OPN; k++) begin : g_lk
    assign is_vec[k]   = vec_tab[arch[k]];
    assign resolved[k] = vec_tab[arch[k]] ? base_tab[arch[k]] : arch[k];
  end

  // R3: predicate keyed on the destination number before remapping
  assign pred_en  = pen_tab[arch[OP_DST]];
  assign pred_src = psrc_tab[arch[OP_DST]];
endmodule

// File: rtl/vseq_ctrl.sv
`timescale 1ns/1ps
module vseq_ctrl import vseq_pkg::*; #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int AW    = 5,
  parameter int VLW   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [VLW-1:0]           cmd_vl,
  input  logic [OPN-1:0]           op_vec,
  input  logic [OPN-1:0][AW-1:0]   op_base,
  input  logic                     pred_en,
  input  logic [XLEN-1:0]          pred_word,
  output logic [1:0][AW-1:0]       src_addr,
  input  logic [1:0][XLEN-1:0]     src_data,
  output logic                     eng_we,
  output logic [AW-1:0]            eng_waddr,
  output logic [XLEN-1:0]          eng_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);
  localparam int FW = AW + 1;
  localparam logic [VLW-1:0] VL_MAX  = VLW'(NREGS);
  localparam logic [FW-1:0]  TOP_IDX = FW'(NREGS - 1);

  seq_state_e        st_q;
  logic [VLW-1:0]    vl_q, idx_q, vl_eff;
  logic [NREGS-1:0]  mask_q;
  logic [OPN-1:0][FW-1:0] full;
  logic [OPN-1:0]    out_rng;
  logic              accept, last, active, any_oor, err_q, running;

  assign accept  = cmd_valid && cmd_ready;
  assign running = (st_q == SQ_RUN);
  assign vl_eff  = (cmd_vl > VL_MAX) ? VL_MAX : cmd_vl;
  assign last    = (idx_q == vl_q - 1'b1);

  // per-operand base capture and offset stepping (R1, R2, R9)
  for (genvar k = 0; k < OPN; k++) begin : g_op
    logic          vec_r;
    logic [AW-1:0] base_r;
    logic [AW-1:0] off_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_r  <= 1'b0;
        base_r <= '0;
        off_r  <= '0;
      end else if (accept) begin
        vec_r  <= op_vec[k];
        base_r <= op_base[k];
        off_r  <= '0;
      end else if (running && vec_r) begin
        off_r  <= off_r + 1'b1;
      end
    end
    assign full[k]    = {1'b0, base_r} + {1'b0, off_r};
    assign out_rng[k] = (full[k] > TOP_IDX);
  end

  assign src_addr[0] = full[OP_SA][AW-1:0];
  assign src_addr[1] = full[OP_SB][AW-1:0];
  assign any_oor     = |out_rng;
  assign active      = running && mask_q[idx_q[AW-1:0]];
  assign eng_waddr   = full[OP_DST][AW-1:0];
  assign eng_wdata   = src_data[0] + src_data[1];
  assign eng_we      = active && !any_oor && (eng_waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      vl_q   <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (accept) begin
          vl_q   <= vl_eff;
          idx_q  <= '0;
          mask_q <= pred_en ? pred_word[NREGS-1:0] : '1;
          err_q  <= 1'b0;
          st_q   <= (vl_eff == '0) ? SQ_FIN : SQ_RUN;
        end
        SQ_RUN: begin
          if (active && any_oor) err_q <= 1'b1;
          idx_q <= idx_q + 1'b1;
          if (last) st_q <= SQ_FIN;
        end
        SQ_FIN:  st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st_q == SQ_IDLE);
  assign busy      = running;
  assign done      = (st_q == SQ_FIN);
  assign err       = err_q;

  p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy || done));
  p_vl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_vl == '0) |=> done);
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !accept) |=> err);
endmodule

// File: rtl/vadd_seq.sv
`timescale 1ns/1ps
module vadd_seq import vseq_pkg::*; #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int AW    = $clog2(NREGS),
  parameter int VLW   = $clog2(NREGS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_rd,
  input  logic [AW-1:0]   cmd_rs1,
  input  logic [AW-1:0]   cmd_rs2,
  input  logic [VLW-1:0]  cmd_vl,
  output logic            busy,
  output logic            done,
  output logic            err,
  input  logic            map_we,
  input  logic [AW-1:0]   map_sel,
  input  logic            map_vec,
  input  logic [AW-1:0]   map_base,
  input  logic            pcfg_we,
  input  logic [AW-1:0]   pcfg_sel,
  input  logic            pcfg_en,
  input  logic [AW-1:0]   pcfg_src,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic [AW-1:0]   rf_raddr,
  output logic [XLEN-1:0] rf_rdata
);
  localparam int NRD = 4;

  logic [OPN-1:0][AW-1:0]  arch, resolved;
  logic [OPN-1:0]          is_vec;
  logic                    pred_en;
  logic [AW-1:0]           pred_src;
  logic [1:0][AW-1:0]      src_addr;
  logic [NRD-1:0][AW-1:0]  rd_addr;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  logic                    eng_we, ext_ok, w_en;
  logic [AW-1:0]           eng_waddr, w_addr;
  logic [XLEN-1:0]         eng_wdata, w_data;

  assign arch = {cmd_rs2, cmd_rs1, cmd_rd};

  vseq_remap #(.NREGS(NREGS), .AW(AW)) u_remap (
    .clk(clk), .rst_n(rst_n),
    .map_we(map_we), .map_sel(map_sel), .map_vec(map_vec), .map_base(map_base),
    .pcfg_we(pcfg_we), .pcfg_sel(pcfg_sel), .pcfg_en(pcfg_en), .pcfg_src(pcfg_src),
    .arch(arch), .is_vec(is_vec), .resolved(resolved),
    .pred_en(pred_en), .pred_src(pred_src)
  );

  vseq_ctrl #(.NREGS(NREGS), .XLEN(XLEN), .AW(AW), .VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_vl(cmd_vl),
    .op_vec(is_vec), .op_base(resolved),
    .pred_en(pred_en), .pred_word(rd_data[2]),
    .src_addr(src_addr), .src_data(rd_data[1:0]),
    .eng_we(eng_we), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
    .busy(busy), .done(done), .err(err)
  );

  // element loop owns the write port while busy (R8)
  assign ext_ok = rf_we && !busy;
  assign w_en   = eng_we || ext_ok;
  assign w_addr = eng_we ? eng_waddr : rf_waddr;
  assign w_data = eng_we ? eng_wdata : rf_wdata;

  assign rd_addr = {rf_raddr, pred_src, src_addr[1], src_addr[0]};

  vseq_regfile #(.NREGS(NREGS), .XLEN(XLEN), .AW(AW), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(w_en), .waddr(w_addr), .wdata(w_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign rf_rdata = rd_data[3];

  p_no_r0_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (eng_waddr != '0));
endmodule

// File: tb/test_vadd_seq.sv
`timescale 1ns/1ps
module test_vadd_seq;
  localparam int NREGS = 32;
  localparam int XLEN  = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, busy, done, err;
  logic [4:0] cmd_rd, cmd_rs1, cmd_rs2;
  logic [5:0] cmd_vl;
  logic map_we, map_vec, pcfg_we, pcfg_en, rf_we;
  logic [4:0] map_sel, map_base, pcfg_sel, pcfg_src, rf_waddr, rf_raddr;
  logic [31:0] rf_wdata, rf_rdata;

  vadd_seq i_vadd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rd(cmd_rd), .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2), .cmd_vl(cmd_vl),
    .busy(busy), .done(done), .err(err),
    .map_we(map_we), .map_sel(map_sel), .map_vec(map_vec), .map_base(map_base),
    .pcfg_we(pcfg_we), .pcfg_sel(pcfg_sel), .pcfg_en(pcfg_en), .pcfg_src(pcfg_src),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [31:0] m_rf   [NREGS];
  logic        m_vec  [NREGS];
  logic [4:0]  m_base [NREGS];
  logic        m_pen  [NREGS];
  logic [4:0]  m_psrc [NREGS];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: act %0d cycles exp completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic ext_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    if (a != 0) m_rf[a] = d;
  endtask

  task automatic set_map(input logic [4:0] r, input logic v, input logic [4:0] b);
    @(negedge clk);
    map_we = 1'b1; map_sel = r; map_vec = v; map_base = b;
    @(negedge clk);
    map_we = 1'b0;
    m_vec[r] = v; m_base[r] = b;
  endtask

  task automatic set_pcfg(input logic [4:0] r, input logic en, input logic [4:0] s);
    @(negedge clk);
    pcfg_we = 1'b1; pcfg_sel = r; pcfg_en = en; pcfg_src = s;
    @(negedge clk);
    pcfg_we = 1'b0;
    m_pen[r] = en; m_psrc[r] = s;
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      rf_raddr = 5'(r);
      #1;
      check(req, rf_rdata, m_rf[r]);
    end
  endtask

  // disturb: during the run, write register 30 and retag rd's table entry
  task automatic run_cmd(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                         input int vl, input bit disturb, input string req);
    int vlc, n, guard, d0, a0, b0, dd, aa, bb;
    logic [31:0] mask;
    logic exp_err;
    vlc  = (vl > NREGS) ? NREGS : vl;
    mask = m_pen[rd] ? m_rf[m_psrc[rd]] : 32'hFFFF_FFFF;
    d0 = m_vec[rd]  ? int'(m_base[rd])  : int'(rd);
    a0 = m_vec[rs1] ? int'(m_base[rs1]) : int'(rs1);
    b0 = m_vec[rs2] ? int'(m_base[rs2]) : int'(rs2);
    exp_err = 1'b0;
    for (int i = 0; i < vlc; i++) begin
      dd = d0 + (m_vec[rd]  ? i : 0);
      aa = a0 + (m_vec[rs1] ? i : 0);
      bb = b0 + (m_vec[rs2] ? i : 0);
      if (mask[i]) begin
        if (dd > 31 || aa > 31 || bb > 31) exp_err = 1'b1;
        else if (dd != 0) m_rf[dd] = m_rf[aa] + m_rf[bb];
      end
    end
    @(negedge clk);
    check({req, " R5 ready idle"}, 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_rs1 = rs1; cmd_rs2 = rs2; cmd_vl = 6'(vl);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0; guard = 0;
    while (!done && guard < 100) begin
      if (busy) n++;
      if (busy && n == 1) check({req, " R5 no ready while busy"}, 32'(cmd_ready), 32'd0);
      if (disturb && guard == 0) begin
        rf_we = 1'b1; rf_waddr = 5'd30; rf_wdata = 32'hDEAD_BEEF;
        map_we = 1'b1; map_sel = rd; map_vec = ~m_vec[rd]; map_base = m_base[rd];
      end
      @(negedge clk);
      if (disturb && guard == 0) begin
        rf_we = 1'b0; map_we = 1'b0;
      end
      guard++;
    end
    if (disturb) m_vec[rd] = ~m_vec[rd];
    check({req, " R5 done"}, 32'(done), 32'd1);
    check({req, " R4 R5 busy length"}, 32'(n), 32'(vlc));
    check({req, " R7 err"}, 32'(err), 32'(exp_err));
    @(negedge clk);
    check({req, " R5 done pulse"}, 32'(done), 32'd0);
    check({req, " R5 ready after"}, 32'(cmd_ready), 32'd1);
    check({req, " R7 err held"}, 32'(err), 32'(exp_err));
    check_all(req);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_rd = '0; cmd_rs1 = '0; cmd_rs2 = '0; cmd_vl = '0;
    map_we = 1'b0; map_sel = '0; map_vec = 1'b0; map_base = '0;
    pcfg_we = 1'b0; pcfg_sel = '0; pcfg_en = 1'b0; pcfg_src = '0;
    rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0; rf_raddr = '0;
    for (int r = 0; r < NREGS; r++) begin
      m_rf[r] = '0; m_vec[r] = 1'b0; m_base[r] = '0; m_pen[r] = 1'b0; m_psrc[r] = '0;
    end
    repeat (3) @(negedge clk);
    check("reset busy", 32'(busy), 32'd0);
    check("reset done", 32'(done), 32'd0);
    check("reset err R7", 32'(err), 32'd0);
    check("reset ready R5", 32'(cmd_ready), 32'd1);
    rst_n = 1'b1;
    check_all("reset regs R6");

    // R8, R6: load registers; the write to register 0 is dropped
    for (int r = 0; r < NREGS; r++) ext_write(5'(r), 32'(r) * 32'h0101_0101 + 32'd5);
    check_all("load R8 R6");

    // R1: all scalar, repeated element on the same registers
    run_cmd(5'd5, 5'd6, 5'd7, 1, 1'b0, "scalar R1");
    run_cmd(5'd5, 5'd6, 5'd7, 3, 1'b0, "scalar R1 R2");

    // R2, R4: vector dst and src1, broadcast src2, all lengths 0..16
    set_map(5'd9, 1'b1, 5'd16);
    set_map(5'd10, 1'b1, 5'd1);
    for (int v = 0; v <= 16; v++) run_cmd(5'd9, 5'd10, 5'd11, v, 1'b0, "sweep R2 R4");

    // R1, R2, R7: every tag combination, in range and one past range
    for (int c = 0; c < 8; c++) begin
      set_map(5'd12, c[0], 5'd20);
      set_map(5'd13, c[1], 5'd2);
      set_map(5'd14, c[2], 5'd5);
      run_cmd(5'd12, 5'd13, 5'd14, 6, 1'b0, "combo R1 R2");
      run_cmd(5'd12, 5'd13, 5'd14, 13, 1'b0, "combo R7");
    end

    // R3: predicate keyed on unmapped rd 9; entry of its base 16 masks everything
    set_pcfg(5'd9, 1'b1, 5'd3);
    set_pcfg(5'd16, 1'b1, 5'd4);
    ext_write(5'd4, 32'h0);
    for (int q = 0; q < 5; q++) begin
      logic [31:0] pat;
      case (q)
        0: pat = 32'h5555_5555;
        1: pat = 32'hAAAA_AAAA;
        2: pat = 32'h0000_0000;
        3: pat = 32'hFFFF_FFFF;
        default: pat = 32'h8000_0001;
      endcase
      ext_write(5'd3, pat);
      run_cmd(5'd9, 5'd10, 5'd11, 16, 1'b0, "pred R3");
    end

    // R7 with R3: overflow only counts on unmasked elements
    set_map(5'd9, 1'b1, 5'd28);
    ext_write(5'd3, 32'h0000_00FF);
    run_cmd(5'd9, 5'd10, 5'd11, 8, 1'b0, "ovf masked-on R7");
    ext_write(5'd3, 32'h0000_000F);
    run_cmd(5'd9, 5'd10, 5'd11, 8, 1'b0, "ovf masked-off R7 R3");

    // R6: vector destination starting at register 0
    set_map(5'd15, 1'b1, 5'd0);
    run_cmd(5'd15, 5'd10, 5'd11, 4, 1'b0, "dst zero R6");

    // R4: length above 32 is clamped
    set_map(5'd9, 1'b1, 5'd0);
    ext_write(5'd3, 32'hFFFF_FFFF);
    run_cmd(5'd9, 5'd10, 5'd11, 40, 1'b0, "clamp R4 R7");

    // R8, R9: writes during the run
    set_map(5'd12, 1'b1, 5'd20);
    set_map(5'd13, 1'b1, 5'd2);
    set_map(5'd14, 1'b1, 5'd5);
    run_cmd(5'd12, 5'd13, 5'd14, 8, 1'b1, "disturb R8 R9");
    run_cmd(5'd12, 5'd13, 5'd14, 2, 1'b0, "after retag R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule